// File: doc/BRIEF.md
# Seconds-Based Watchdog and Countdown Timer

This block is an 8-bit down-counter driven by one of several slow tick inputs, such as 1 Hz or 1/60 Hz enables produced elsewhere on the chip. Software sets up the block through a small register port. One register picks the tick source. One holds the start value. A third holds the mode and the interrupt style. The control register carries the interrupt enables and the expiry flags. The count reaches zero one tick period for each unit of the start value, so a start value of 240 at 1 Hz gives an alarm four minutes later with one-second resolution.

There are two operating modes. In countdown mode the counter reloads itself each time it expires, which gives a periodic event. In watchdog mode it stops at zero and waits for a new start value. Each mode has its own flag and its own enable. The watchdog flag cannot be written: reading the control register clears it. The countdown flag is cleared by writing zero to its bit. The interrupt output follows the enabled flags as a level. In pulsed style it is instead a pulse that lasts one source-tick period.

Top module: `sec_down_timer`

## Requirements
- R1: After reset, every register reads 0x00 and `irq` is low.
- R2: Bits 2:1 of the mode register (address 1) select the mode: 01 is countdown, 10 is watchdog, and 00 or 11 stop the counter, which then holds its value.
- R3: Bits 2:0 of the select register (address 2) pick `src_tick[code]` as the count source; code 010 is the 1 Hz input by convention. A code of `NSRC` or more selects no source, and the counter never moves.
- R4: Writing the count register (address 3) stores the start value and loads the counter at once. Reading address 3 returns the live count. Each selected tick in an active mode lowers a nonzero count by one.
- R5: In countdown mode, a tick that finds the count at 1 sets the countdown flag (control bit 6) and reloads the counter with the stored start value.
- R6: In watchdog mode, a tick that finds the count at 1 sets the watchdog flag (control bit 7). The counter then stays at 0 until the count register is written.
- R7: Reading the control register (address 0) clears the watchdog flag after the read. If an expiry falls in the same cycle as the read, the flag is set and stays set.
- R8: A control write stores the enables: bit 2 for watchdog and bit 1 for countdown. It clears the countdown flag when bit 6 is 0. Writing 1 to bit 6 or to bit 7 has no effect on either flag.
- R9: When mode bit 7 is 0, `irq` is high exactly while some flag is set together with its enable.
- R10: When mode bit 7 is 1, an expiry whose enable is set drives `irq` high. It stays high until the next selected tick, even though the flag remains set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_tick | input | NSRC | One-cycle enable pulses, one per source frequency |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (a read of address 0 clears the watchdog flag) |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt, level or pulsed |

## Verification
The assertions assume that each tick input is high for at most one core cycle at a time. They also assume that read and write strobes are single-cycle requests held steady around the clock edge. A count that is reloaded in the same cycle as a tick is expected to take the written value. The bench drives every strobe and tick for exactly one cycle, on the falling edge. It leaves idle cycles between ticks, so no source ever presents back-to-back pulses. The single collision it creates on purpose is a control read in the same cycle as an expiry.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

  typedef enum logic [1:0] {
    TM_OFF   = 2'b00,
    TM_COUNT = 2'b01,
    TM_WATCH = 2'b10,
    TM_RSVD  = 2'b11
  } tmode_e;

  // control register bit positions
  localparam int CTL_WD_FLAG = 7;
  localparam int CTL_CD_FLAG = 6;
  localparam int CTL_WD_IE   = 2;
  localparam int CTL_CD_IE   = 1;

  // mode register bit positions
  localparam int MOD_PULSE = 7;
  localparam int MOD_LO    = 1;

  // register addresses
  localparam int ADR_CTRL = 0;
  localparam int ADR_MODE = 1;
  localparam int ADR_SEL  = 2;
  localparam int ADR_CNT  = 3;

endpackage

// File: rtl/sdt_tick_sel.sv
module sdt_tick_sel #(
  parameter int NSRC  = 5,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);

  logic [NSRC-1:0] hit;

  generate
    for (genvar gi = 0; gi < NSRC; gi++) begin : g_src
      assign hit[gi] = src_tick[gi] & (sel == SEL_W'(gi));
    end
  endgenerate

  assign tick = |hit;

  // R3: an out-of-range code never yields a tick
  a_r3_no_tick_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(sel) >= NSRC) |-> !tick);

endmodule

// File: rtl/sdt_counter.sv
module sdt_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run_cd,
  input  logic             run_wd,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic [CNT_W-1:0] reload_val,
  output logic [CNT_W-1:0] cnt,
  output logic             expire
);

  localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] C_ZERO = '0;

  logic             active;
  logic             step;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] cnt_q;

  assign active = run_cd | run_wd;
  assign step   = tick & active & (cnt_q != C_ZERO);
  assign expire = step & (cnt_q == C_ONE);

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load) begin
      cnt_en = 1'b1;
      cnt_d  = load_val;
    end else if (expire) begin
      cnt_en = 1'b1;
      cnt_d  = run_cd ? reload_val : C_ZERO;
    end else if (step) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - C_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;

  // R2: a stopped counter holds unless written
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_cd && !run_wd && !load) |=> $stable(cnt_q));

  // R4: without a tick or a write the count never moves
  a_r4_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load) |=> $stable(cnt_q));

  // R5: countdown expiry restarts from the stored start value
  a_r5_cd_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && run_cd && !load) |=> (cnt_q == $past(reload_val)));

  // R6: watchdog parks at zero until written
  a_r6_wd_park: assert property (@(posedge clk) disable iff (!rst_n)
    (run_wd && (cnt_q == C_ZERO) && !load) |=> (cnt_q == C_ZERO));

endmodule

// File: rtl/sdt_status.sv
module sdt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_ctrl,
  input  logic wr_wd_ie,
  input  logic wr_cd_ie,
  input  logic wr_cd_keep,
  input  logic rd_ctrl,
  input  logic expire,
  input  logic run_cd,
  input  logic run_wd,
  input  logic tick,
  input  logic pulsed,
  output logic wd_flag,
  output logic cd_flag,
  output logic wd_ie,
  output logic cd_ie,
  output logic irq
);

  logic wd_flag_q, wd_flag_d;
  logic cd_flag_q, cd_flag_d;
  logic wd_ie_q, wd_ie_d;
  logic cd_ie_q, cd_ie_d;
  logic pulse_q, pulse_d;
  logic wd_hit, cd_hit;
  logic level;

  assign wd_hit = expire & run_wd;
  assign cd_hit = expire & run_cd;

  always_comb begin
    wd_ie_d = wd_ie_q;
    cd_ie_d = cd_ie_q;
    if (wr_ctrl) begin
      wd_ie_d = wr_wd_ie;
      cd_ie_d = wr_cd_ie;
    end
  end

  always_comb begin
    wd_flag_d = wd_flag_q;
    if (wd_hit) begin
      wd_flag_d = 1'b1;
    end else if (rd_ctrl) begin
      wd_flag_d = 1'b0;
    end
  end

  always_comb begin
    cd_flag_d = cd_flag_q;
    if (cd_hit) begin
      cd_flag_d = 1'b1;
    end else if (wr_ctrl && !wr_cd_keep) begin
      cd_flag_d = 1'b0;
    end
  end

  always_comb begin
    pulse_d = pulse_q;
    if ((wd_hit && wd_ie_q) || (cd_hit && cd_ie_q)) begin
      pulse_d = 1'b1;
    end else if (tick) begin
      pulse_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wd_flag_q <= 1'b0;
      cd_flag_q <= 1'b0;
      wd_ie_q   <= 1'b0;
      cd_ie_q   <= 1'b0;
      pulse_q   <= 1'b0;
    end else begin
      wd_flag_q <= wd_flag_d;
      cd_flag_q <= cd_flag_d;
      wd_ie_q   <= wd_ie_d;
      cd_ie_q   <= cd_ie_d;
      pulse_q   <= pulse_d;
    end
  end

  assign level   = (wd_flag_q & wd_ie_q) | (cd_flag_q & cd_ie_q);
  assign irq     = pulsed ? pulse_q : level;
  assign wd_flag = wd_flag_q;
  assign cd_flag = cd_flag_q;
  assign wd_ie   = wd_ie_q;
  assign cd_ie   = cd_ie_q;

  // R7: a control read clears the watchdog flag unless an expiry collides
  a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ctrl && !wd_hit) |=> !wd_flag_q);

  // R7: collision keeps the flag
  a_r7_collision_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wd_hit |=> wd_flag_q);

  // R8: writing a one to bit 6 never clears the countdown flag
  a_r8_keep_cd: assert property (@(posedge clk) disable iff (!rst_n)
    (cd_flag_q && wr_ctrl && wr_cd_keep) |=> cd_flag_q);

  // R9: level interrupt needs a flag behind it
  a_r9_level_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!pulsed && irq) |-> (wd_flag_q || cd_flag_q));

  // R10: the pulse ends at the next selected tick
  a_r10_pulse_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (pulsed && pulse_q && tick && !expire) |=> !pulse_q);

endmodule

// File: rtl/sec_down_timer.sv
module sec_down_timer
  import sdt_pkg::*;
#(
  parameter int NSRC   = 5,
  parameter int SEL_W  = 3,
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src_tick,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);

  localparam int CNT_W = DATA_W;

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= 2'b00;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end

  assign rst_core_n = rst_pipe[1];

  // address decode
  logic wr_ctrl, wr_mode, wr_sel, wr_cnt, rd_ctrl;

  assign wr_ctrl = bus_wr & (bus_addr == ADDR_W'(ADR_CTRL));
  assign wr_mode = bus_wr & (bus_addr == ADDR_W'(ADR_MODE));
  assign wr_sel  = bus_wr & (bus_addr == ADDR_W'(ADR_SEL));
  assign wr_cnt  = bus_wr & (bus_addr == ADDR_W'(ADR_CNT));
  assign rd_ctrl = bus_rd & (bus_addr == ADDR_W'(ADR_CTRL));

  // configuration registers
  tmode_e           mode_q, mode_d;
  logic             pulsed_q, pulsed_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [CNT_W-1:0] reload_q, reload_d;

  always_comb begin
    mode_d   = mode_q;
    pulsed_d = pulsed_q;
    sel_d    = sel_q;
    reload_d = reload_q;
    if (wr_mode) begin
      mode_d   = tmode_e'(bus_wdata[MOD_LO+1:MOD_LO]);
      pulsed_d = bus_wdata[MOD_PULSE];
    end
    if (wr_sel) begin
      sel_d = bus_wdata[SEL_W-1:0];
    end
    if (wr_cnt) begin
      reload_d = bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      mode_q   <= TM_OFF;
      pulsed_q <= 1'b0;
      sel_q    <= '0;
      reload_q <= '0;
    end else begin
      mode_q   <= mode_d;
      pulsed_q <= pulsed_d;
      sel_q    <= sel_d;
      reload_q <= reload_d;
    end
  end

  logic run_cd, run_wd;
  assign run_cd = (mode_q == TM_COUNT);
  assign run_wd = (mode_q == TM_WATCH);

  // datapath
  logic             tick;
  logic             expire;
  logic [CNT_W-1:0] cnt;
  logic             wd_flag, cd_flag, wd_ie, cd_ie;

  sdt_tick_sel #(
    .NSRC  (NSRC),
    .SEL_W (SEL_W)
  ) u_sel (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .src_tick (src_tick),
    .sel      (sel_q),
    .tick     (tick)
  );

  sdt_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .tick       (tick),
    .run_cd     (run_cd),
    .run_wd     (run_wd),
    .load       (wr_cnt),
    .load_val   (bus_wdata[CNT_W-1:0]),
    .reload_val (reload_q),
    .cnt        (cnt),
    .expire     (expire)
  );

  sdt_status u_stat (
    .clk        (clk),
    .rst_n      (rst_core_n),
    .wr_ctrl    (wr_ctrl),
    .wr_wd_ie   (bus_wdata[CTL_WD_IE]),
    .wr_cd_ie   (bus_wdata[CTL_CD_IE]),
    .wr_cd_keep (bus_wdata[CTL_CD_FLAG]),
    .rd_ctrl    (rd_ctrl),
    .expire     (expire),
    .run_cd     (run_cd),
    .run_wd     (run_wd),
    .tick       (tick),
    .pulsed     (pulsed_q),
    .wd_flag    (wd_flag),
    .cd_flag    (cd_flag),
    .wd_ie      (wd_ie),
    .cd_ie      (cd_ie),
    .irq        (irq)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (int'(bus_addr))
      ADR_CTRL: begin
        bus_rdata[CTL_WD_FLAG] = wd_flag;
        bus_rdata[CTL_CD_FLAG] = cd_flag;
        bus_rdata[CTL_WD_IE]   = wd_ie;
        bus_rdata[CTL_CD_IE]   = cd_ie;
      end
      ADR_MODE: begin
        bus_rdata[MOD_PULSE]         = pulsed_q;
        bus_rdata[MOD_LO+1:MOD_LO]   = mode_q;
      end
      ADR_SEL:  bus_rdata[SEL_W-1:0] = sel_q;
      ADR_CNT:  bus_rdata[CNT_W-1:0] = cnt;
      default:  bus_rdata = '0;
    endcase
  end

  // R6: a watchdog flag only rises while in watchdog mode
  a_r6_wd_flag_mode: assert property (@(posedge clk) disable iff (!rst_core_n)
    $rose(wd_flag) |-> $past(run_wd));

  // R1: irq low while held in reset
  a_r1_reset_quiet: assert property (@(posedge clk) !rst_core_n |-> !irq);

endmodule

// File: tb/sec_down_timer_tb.sv
module sec_down_timer_tb;

  localparam int NSRC = 5;

  logic            clk;
  logic            rst_n;
  logic [NSRC-1:0] src_tick;
  logic            bus_wr;
  logic            bus_rd;
  logic [1:0]      bus_addr;
  logic [7:0]      bus_wdata;
  logic [7:0]      bus_rdata;
  logic            irq;

  int n_tests;
  int n_fail;
  bit done;

  sec_down_timer u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_tick  (src_tick),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {mode[39:38], sel[37:35], line[34:32], start[31:24], ticks[23:16], exp_cnt[15:8], exp_ctrl[7:0]}
  localparam int NVEC = 11;
  localparam logic [39:0] VEC [NVEC] = '{
    {2'b01, 3'd2, 3'd2, 8'd5, 8'd3, 8'd2, 8'h00},  // R4 partial countdown
    {2'b01, 3'd2, 3'd2, 8'd5, 8'd5, 8'd5, 8'h40},  // R5 expiry reloads
    {2'b01, 3'd2, 3'd2, 8'd3, 8'd7, 8'd2, 8'h40},  // R5 two periods
    {2'b10, 3'd2, 3'd2, 8'd4, 8'd4, 8'd0, 8'h80},  // R6 watchdog expiry
    {2'b10, 3'd2, 3'd2, 8'd4, 8'd9, 8'd0, 8'h80},  // R6 parks at zero
    {2'b00, 3'd2, 3'd2, 8'd4, 8'd3, 8'd4, 8'h00},  // R2 off holds
    {2'b11, 3'd2, 3'd2, 8'd4, 8'd3, 8'd4, 8'h00},  // R2 reserved holds
    {2'b01, 3'd2, 3'd0, 8'd4, 8'd3, 8'd4, 8'h00},  // R3 unselected line
    {2'b01, 3'd0, 3'd0, 8'd2, 8'd2, 8'd2, 8'h40},  // R3 source 0
    {2'b01, 3'd7, 3'd0, 8'd4, 8'd3, 8'd4, 8'h00},  // R3 code out of range
    {2'b10, 3'd4, 3'd4, 8'd1, 8'd1, 8'd0, 8'h80}   // R6 minimum start
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic tk(input int line);
    @(negedge clk);
    src_tick[line] = 1'b1;
    @(negedge clk);
    src_tick = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: got hang expected finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    n_tests = 0; n_fail = 0; done = 0;
    src_tick = '0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1 reset reg", v, 8'h00);
    end
    check("R1 reset irq", {7'b0, irq}, 8'h00);

    // table walk
    for (int k = 0; k < NVEC; k++) begin
      wr(2'd1, {5'b0, VEC[k][39:38], 1'b0});
      wr(2'd2, {5'b0, VEC[k][37:35]});
      wr(2'd3, VEC[k][31:24]);
      wr(2'd0, 8'h00);
      for (int t = 0; t < int'(VEC[k][23:16]); t++) tk(int'(VEC[k][34:32]));
      rd(2'd3, v);
      check($sformatf("R4 vec%0d count", k), v, VEC[k][15:8]);
      rd(2'd0, v);
      check($sformatf("R5 R6 vec%0d ctrl", k), v, VEC[k][7:0]);
    end

    // R8 flag write rules
    wr(2'd1, 8'h02); wr(2'd2, 8'h02); wr(2'd3, 8'd1); wr(2'd0, 8'h00);
    wr(2'd0, 8'h80);
    rd(2'd0, v); check("R8 bit7 write no set", v, 8'h00);
    tk(2);
    wr(2'd0, 8'hC0);
    rd(2'd0, v); check("R8 bit6 one keeps", v, 8'h40);
    wr(2'd0, 8'h00);
    rd(2'd0, v); check("R8 bit6 zero clears", v, 8'h00);

    // R7 read clears, write does not
    wr(2'd1, 8'h04); wr(2'd3, 8'd1); tk(2);
    wr(2'd0, 8'h00);
    rd(2'd0, v); check("R7 write keeps wd flag", v, 8'h80);
    rd(2'd0, v); check("R7 read cleared", v, 8'h00);

    // R7 collision: read and expiry in the same cycle
    wr(2'd3, 8'd1);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 2'd0; src_tick[2] = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; src_tick = '0;
    check("R7 collision pre", v, 8'h00);
    rd(2'd0, v); check("R7 collision set wins", v, 8'h80);

    // R9 level interrupt
    wr(2'd1, 8'h02); wr(2'd0, 8'h00); wr(2'd3, 8'd1);
    tk(2);
    check("R9 disabled no irq", {7'b0, irq}, 8'h00);
    wr(2'd0, 8'h42);
    check("R9 enabled irq", {7'b0, irq}, 8'h01);
    tk(2);
    check("R9 level holds", {7'b0, irq}, 8'h01);
    wr(2'd0, 8'h02);
    check("R9 cleared irq", {7'b0, irq}, 8'h00);

    // R10 pulsed interrupt
    wr(2'd1, 8'h84); wr(2'd0, 8'h04); wr(2'd3, 8'd2);
    tk(2);
    check("R10 before expiry", {7'b0, irq}, 8'h00);
    tk(2);
    check("R10 pulse high", {7'b0, irq}, 8'h01);
    repeat (3) @(negedge clk);
    check("R10 pulse holds", {7'b0, irq}, 8'h01);
    tk(2);
    check("R10 pulse ends", {7'b0, irq}, 8'h00);
    rd(2'd0, v); check("R10 flag stays", v, 8'h84);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule